// File: doc/BRIEF.md
# E1 Timeslot-Zero Double-Frame Capture

This block sits behind an E1 framer that has already found frame alignment. It sees the received serial stream one bit at a time through a bit-valid strobe. Alongside the stream it gets a frame-start marker on the first bit of every frame, and a flag that tells an align frame from a non-align frame. The block gathers the timeslot-0 byte of an align frame and the timeslot-0 byte of the non-align frame right after it. It keeps that pair in holding storage. When the next align frame begins, it copies the pair into two host-visible words. The bits are passed on unfiltered: the international bit, the alignment pattern and the spare bits all appear exactly as they arrived.

Each copy sets a sticky "new data" flag, and a one-cycle host clear input drops it. If a copy happens while the flag is still set and no clear arrives with it, an overrun flag is set. The host then has one double-frame period to read both words before they are replaced. A sequencer state machine tracks the double-frame and has these states:

- `ST_IDLE`: no usable align capture.
- `ST_CAP_ALN`: shifting in the align byte.
- `ST_WAIT_NAL`: align byte held, waiting for the next frame.
- `ST_CAP_NAL`: shifting in the non-align byte.
- `ST_PAIR_RDY`: a complete pair is held.

It moves between them on these events:

- An align frame start enters `ST_CAP_ALN` from any state. From `ST_PAIR_RDY` it also publishes the pair.
- A non-align frame start enters `ST_CAP_NAL` from `ST_WAIT_NAL`. From any other state it returns to `ST_IDLE`.
- A full shifter ends a capture: `ST_CAP_ALN` goes to `ST_WAIT_NAL`, and `ST_CAP_NAL` goes to `ST_PAIR_RDY`.

Top module: `e1_ts0_dframe_cap`

## Requirements
- R1: After reset both published words read 0x00 and both the new-data flag and the overrun flag read 0.
- R2: Within timeslot 0 the first bit received (the one flagged by frame start) lands in word bit 7 and the eighth lands in bit 0. The align word carries the international bit in bit 7 and the alignment pattern in bits 6..0 as received, with no checking.
- R3: At the start bit of an align frame (bit_en, frm_start and frm_is_align all high), if an align byte and the non-align byte that directly followed it are both complete, both words load that pair in the same clock. The new values are visible in the cycle after the start bit.
- R4: At every other time the published words keep their value. This includes when the sequence is broken, in which case the partial pair is discarded:
  - two align frames in a row;
  - a non-align frame that does not directly follow an align capture.
- R5: Each publication sets upd_flag, and upd_flag stays set until a cycle with host_clr high. That cycle clears it from the next cycle on, provided no publication happens in the same cycle.
- R6: When host_clr and a publication fall in the same cycle, upd_flag stays 1 and ovr_flag reads 0 afterwards.
- R7: A publication while upd_flag is 1 and host_clr is 0 sets ovr_flag. ovr_flag is sticky until a host_clr cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies bit_in as a valid received bit |
| bit_in | input | 1 | Received serial data bit |
| frm_start | input | 1 | With bit_en, marks the first bit of a frame |
| frm_is_align | input | 1 | With frm_start, 1 for an align frame, 0 for a non-align frame |
| host_clr | input | 1 | One-cycle pulse clearing upd_flag and ovr_flag |
| aln_word | output | 8 | Published timeslot-0 byte of the align frame |
| nal_word | output | 8 | Published timeslot-0 byte of the non-align frame |
| upd_flag | output | 1 | Sticky new-pair flag |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
A host clear and a publication can fall in the same clock. In that case the publication must win for the new-data flag, and the clear must still wipe any pending overrun. The bench provokes this by raising host_clr on the very start bit of an align frame that closes a complete pair, while the flag is still set from the previous pair. The scoreboard entry for that publication expects upd_flag 1 and ovr_flag 0. A separate publication with no clear pending is expected to raise ovr_flag, so the two outcomes are told apart.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CAP_ALN  = 3'd1,
        ST_WAIT_NAL = 3'd2,
        ST_CAP_NAL  = 3'd3,
        ST_PAIR_RDY = 3'd4
    } dfr_state_e;

endpackage

// File: rtl/ts0_shifter.sv
module ts0_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         restart_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            sh_q <= {sh_q[W-2:0], bit_i};
            if (restart_i) begin
                cnt_q <= CW'(1);
            end else if (cnt_q != CW'(W)) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign data_o = sh_q;
    assign full_o = (cnt_q == CW'(W));
endmodule

// File: rtl/dfr_seq_fsm.sv
module dfr_seq_fsm
    import e1_ts0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       frm_start,
    input  logic       frm_is_align,
    input  logic       full_i,
    output logic       shift_o,
    output logic       restart_o,
    output logic       store_aln_o,
    output logic       store_nal_o,
    output logic       publish_o,
    output dfr_state_e state_o
);
    dfr_state_e st_q, st_d;
    logic start_aln, start_nal;

    assign start_aln = bit_en & frm_start & frm_is_align;
    assign start_nal = bit_en & frm_start & ~frm_is_align;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d        = st_q;
        shift_o     = 1'b0;
        restart_o   = 1'b0;
        store_aln_o = 1'b0;
        store_nal_o = 1'b0;
        publish_o   = 1'b0;
        if (start_aln) begin
            st_d      = ST_CAP_ALN;
            shift_o   = 1'b1;
            restart_o = 1'b1;
            publish_o = (st_q == ST_PAIR_RDY);
        end else if (start_nal) begin
            if (st_q == ST_WAIT_NAL) begin
                st_d      = ST_CAP_NAL;
                shift_o   = 1'b1;
                restart_o = 1'b1;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_IDLE, ST_WAIT_NAL, ST_PAIR_RDY: begin
                    st_d = st_q;
                end
                ST_CAP_ALN: begin
                    if (full_i) begin
                        store_aln_o = 1'b1;
                        st_d        = ST_WAIT_NAL;
                    end else if (bit_en) begin
                        shift_o = 1'b1;
                    end
                end
                ST_CAP_NAL: begin
                    if (full_i) begin
                        store_nal_o = 1'b1;
                        st_d        = ST_PAIR_RDY;
                    end else if (bit_en) begin
                        shift_o = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/dfr_publish.sv
module dfr_publish #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_i,
    input  logic         store_aln_i,
    input  logic         store_nal_i,
    input  logic         publish_i,
    input  logic         host_clr,
    output logic [W-1:0] aln_o,
    output logic [W-1:0] nal_o,
    output logic         upd_o,
    output logic         ovr_o
);
    logic [W-1:0] hold_aln_q, hold_nal_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_aln_q <= '0;
            hold_nal_q <= '0;
        end else begin
            if (store_aln_i) hold_aln_q <= cap_i;
            if (store_nal_i) hold_nal_q <= cap_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aln_o <= '0;
            nal_o <= '0;
        end else if (publish_i) begin
            aln_o <= hold_aln_q;
            nal_o <= hold_nal_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_o <= 1'b0;
            ovr_o <= 1'b0;
        end else begin
            if (publish_i) begin
                upd_o <= 1'b1;
            end else if (host_clr) begin
                upd_o <= 1'b0;
            end
            if (publish_i && upd_o && !host_clr) begin
                ovr_o <= 1'b1;
            end else if (host_clr) begin
                ovr_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/e1_ts0_dframe_cap.sv
module e1_ts0_dframe_cap
    import e1_ts0_pkg::*;
#(
    parameter int TS_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic               frm_start,
    input  logic               frm_is_align,
    input  logic               host_clr,
    output logic [TS_BITS-1:0] aln_word,
    output logic [TS_BITS-1:0] nal_word,
    output logic               upd_flag,
    output logic               ovr_flag
);
    logic [TS_BITS-1:0] cap_w;
    logic full_w, shift_w, restart_w, st_aln_w, st_nal_w, pub_w;
    dfr_state_e state_w;

    ts0_shifter #(.W(TS_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (shift_w),
        .restart_i (restart_w),
        .bit_i     (bit_in),
        .data_o    (cap_w),
        .full_o    (full_w)
    );

    dfr_seq_fsm u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .frm_start    (frm_start),
        .frm_is_align (frm_is_align),
        .full_i       (full_w),
        .shift_o      (shift_w),
        .restart_o    (restart_w),
        .store_aln_o  (st_aln_w),
        .store_nal_o  (st_nal_w),
        .publish_o    (pub_w),
        .state_o      (state_w)
    );

    dfr_publish #(.W(TS_BITS)) u_pub (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap_w),
        .store_aln_i (st_aln_w),
        .store_nal_i (st_nal_w),
        .publish_i   (pub_w),
        .host_clr    (host_clr),
        .aln_o       (aln_word),
        .nal_o       (nal_word),
        .upd_o       (upd_flag),
        .ovr_o       (ovr_flag)
    );
endmodule

// File: rtl/e1_ts0_dframe_cap_chk.sv
module e1_ts0_dframe_cap_chk
    import e1_ts0_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_en,
    input logic         frm_start,
    input logic         frm_is_align,
    input logic         host_clr,
    input logic [W-1:0] aln_word,
    input logic [W-1:0] nal_word,
    input logic         upd_flag,
    input logic         ovr_flag,
    input dfr_state_e   st
);
    logic aln_start;
    assign aln_start = bit_en && frm_start && frm_is_align;

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aln_start |=> ($stable(aln_word) && $stable(nal_word))); // R4

    AST_PAIR_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
        (aln_start && st == ST_PAIR_RDY) |=> upd_flag); // R3

    AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_flag) |-> $past(aln_start)); // R5

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && !(aln_start && st == ST_PAIR_RDY)) |=> (!upd_flag && !ovr_flag)); // R5

    AST_CLR_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && aln_start && st == ST_PAIR_RDY) |=> (upd_flag && !ovr_flag)); // R6

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(upd_flag) && !$past(host_clr))); // R7
endmodule

bind e1_ts0_dframe_cap e1_ts0_dframe_cap_chk #(.W(TS_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .frm_start    (frm_start),
    .frm_is_align (frm_is_align),
    .host_clr     (host_clr),
    .aln_word     (aln_word),
    .nal_word     (nal_word),
    .upd_flag     (upd_flag),
    .ovr_flag     (ovr_flag),
    .st           (state_w)
);

// File: tb/e1_ts0_dframe_cap_test.sv
module e1_ts0_dframe_cap_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILL       = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, bit_in = 1'b0, frm_start = 1'b0, frm_is_align = 1'b0, host_clr = 1'b0;
    logic [7:0] aln_word, nal_word;
    logic upd_flag, ovr_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_ts0_dframe_cap #(.TS_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .frm_start(frm_start), .frm_is_align(frm_is_align), .host_clr(host_clr),
        .aln_word(aln_word), .nal_word(nal_word),
        .upd_flag(upd_flag), .ovr_flag(ovr_flag)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [17:0] exp_q[$];

    logic [7:0] m_cur_a = 8'h00, m_pair_a = 8'h00, m_pair_n = 8'h00;
    logic [7:0] m_pub_a = 8'h00, m_pub_n = 8'h00;
    bit m_a_ok = 1'b0, m_pair_rdy = 1'b0, m_upd = 1'b0, m_ovr = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        bit_en = 1'b0; frm_start = 1'b0; host_clr = 1'b0;
    endtask

    // driver: sends one frame (timeslot 0 byte MSB first, then filler), pushes expectations
    task automatic send_frame(input logic [7:0] ts0, input logic al, input logic clr_first);
        bit pub;
        pub = al && m_pair_rdy;
        @(negedge clk);
        bit_en = 1'b1; bit_in = ts0[7]; frm_start = 1'b1; frm_is_align = al; host_clr = clr_first;
        if (pub) begin
            if (m_upd && !clr_first) m_ovr = 1'b1;
            else if (clr_first)      m_ovr = 1'b0;
            m_upd   = 1'b1;
            m_pub_a = m_pair_a;
            m_pub_n = m_pair_n;
            exp_q.push_back({m_pub_a, m_pub_n, m_upd, m_ovr});
        end else if (clr_first) begin
            m_upd = 1'b0;
            m_ovr = 1'b0;
        end
        if (al) begin
            m_pair_rdy = 1'b0;
            m_cur_a    = ts0;
            m_a_ok     = 1'b1;
        end else begin
            if (m_a_ok) begin
                m_pair_a   = m_cur_a;
                m_pair_n   = ts0;
                m_pair_rdy = 1'b1;
            end else begin
                m_pair_rdy = 1'b0;
            end
            m_a_ok = 1'b0;
        end
        idle_cycle();
        if (!pub) begin
            chk("R4 align word held", aln_word, m_pub_a);
            chk("R4 nonalign word held", nal_word, m_pub_n);
            chk("R4 flag unchanged", upd_flag, m_upd);
        end
        for (int i = 6; i >= 0; i--) begin
            @(negedge clk);
            bit_en = 1'b1; bit_in = ts0[i]; frm_start = 1'b0;
            idle_cycle();
        end
        for (int k = 0; k < FILL; k++) begin
            @(negedge clk);
            bit_en = 1'b1; bit_in = k[0]; frm_start = 1'b0;
            idle_cycle();
        end
    endtask

    task automatic host_clear();
        @(negedge clk);
        bit_en = 1'b0; host_clr = 1'b1;
        m_upd = 1'b0;
        m_ovr = 1'b0;
        @(negedge clk);
        host_clr = 1'b0;
        chk("R5 flag cleared", upd_flag, 1'b0);
        chk("R7 overrun cleared", ovr_flag, 1'b0);
    endtask

    // monitor: pops scoreboard entries in the cycle a publication becomes visible
    always @(posedge clk) begin
        logic [17:0] e;
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk("R2 R3 align word", aln_word, e[17:10]);
            chk("R2 R3 nonalign word", nal_word, e[9:2]);
            chk("R5 R6 update flag", upd_flag, e[1]);
            chk("R6 R7 overrun flag", ovr_flag, e[0]);
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset align word", aln_word, 8'h00);
        chk("R1 reset nonalign word", nal_word, 8'h00);
        chk("R1 reset update flag", upd_flag, 1'b0);
        chk("R1 reset overrun flag", ovr_flag, 1'b0);

        send_frame(8'h1B, 1'b1, 1'b0);   // no pair yet
        send_frame(8'h5F, 1'b0, 1'b0);
        send_frame(8'h9B, 1'b1, 1'b0);   // publishes 1B/5F
        send_frame(8'h40, 1'b0, 1'b0);
        send_frame(8'h1B, 1'b1, 1'b0);   // publishes 9B/40 with flag set -> overrun
        send_frame(8'h7F, 1'b0, 1'b0);
        host_clear();
        send_frame(8'h1B, 1'b1, 1'b0);   // publishes 1B/7F
        send_frame(8'hA5, 1'b0, 1'b0);
        send_frame(8'h3C, 1'b1, 1'b1);   // R6: clear and publication coincide
        send_frame(8'h66, 1'b1, 1'b0);   // align after align: nothing to publish
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);   // second non-align discards pair
        send_frame(8'h33, 1'b1, 1'b0);   // nothing to publish
        send_frame(8'h44, 1'b0, 1'b0);
        send_frame(8'h55, 1'b1, 1'b0);   // publishes 33/44 with flag set -> overrun
        repeat (4) idle_cycle();
        chk("R7 overrun sticky", ovr_flag, 1'b1);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule